// File: doc/BRIEF.md
# Configuration Port Address/Data Decoder

This block sits on the host side of a processor I/O bus and turns port cycles into configuration-space requests. The two-register scheme works as follows. Software first writes a 32-bit address word into an address latch at one I/O port. It then reads or writes a four-byte data window at a second port. The latch supplies the bus number, the device/function number and a 12-bit register offset. The data window access supplies the size, the byte lane and, for writes, the data.

Each enabled access to the data window becomes one request on a downstream configuration interface. That request carries byte enables and lane-aligned write data. The block holds the request until the downstream side acknowledges it. Read data comes back shifted down to the low lanes. A request that nobody answers returns all ones.

Only a full 32-bit access at the address port reaches the latch. Byte and word probes of that port range therefore leave the latch alone. Four extra offset bits in the latch, above the bus field, give each function a 4096-byte space.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the latch reads 0x00000000, `io_ready` is low and `cfg_valid` is low.
- R2: A dword (size code 2) write at `ADDR_PORT` stores latch bits 31 and 27:2; bits 30:28 and 1:0 always read as zero. A dword read there returns the latch. Either access raises `io_ready` one cycle after the strobe is first sampled.
- R3: Byte (size 0) or word (size 1) accesses to `ADDR_PORT`..`ADDR_PORT+3` leave the latch unchanged. They issue no request, and reads return all ones masked to the access size.
- R4: A forwarded request carries `cfg_bus` = latch[23:16], `cfg_devfn` = latch[15:8] and `cfg_reg` = {latch[27:24], latch[7:2], 2'b00}.
- R5: Byte enables follow the size code and the port offset o = address[1:0] within the window. A byte access gives 1<<o. A word access (o even) gives 3<<o. A dword access (o = 0) gives 4'hF. A misaligned access (odd-offset word, or dword with o ≠ 0) is not forwarded, and its reads return all ones.
- R6: On writes, `cfg_wdata` holds `io_wdata` shifted up by 8*o bits in the enabled lanes.
- R7: On reads, `io_rdata` equals `cfg_rdata` shifted down by 8*o bits and masked to 8, 16 or 32 bits, with the unused upper bits zero.
- R8: While latch bit 31 is clear, data-window accesses issue no request. Reads return all ones masked to the size, and writes are dropped.
- R9: When `cfg_err` is high with `cfg_ack`, the read returns all ones masked to the size.
- R10: `cfg_valid` stays high, with stable fields, until `cfg_ack`. `io_ready` rises the cycle after `cfg_ack` is sampled, so a downstream delay of d cycles gives an access latency of 2+d cycles. `io_ready` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | IO_AW | I/O port address, held until `io_ready` |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_rd | input | 1 | Read strobe, held until `io_ready` |
| io_wr | input | 1 | Write strobe, held until `io_ready` |
| io_wdata | input | DATA_W | Write data, right-aligned |
| io_rdata | output | DATA_W | Read data, right-aligned, valid with `io_ready` |
| io_ready | output | 1 | One-cycle access completion |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | BUS_W | Target bus number |
| cfg_devfn | output | DEVFN_W | Target device/function |
| cfg_reg | output | REG_W | Dword-aligned register offset |
| cfg_be | output | DATA_W/8 | Byte enables |
| cfg_wdata | output | DATA_W | Lane-aligned write data |
| cfg_rdata | input | DATA_W | Returned read data, full dword |
| cfg_ack | input | 1 | Request completion |
| cfg_err | input | 1 | No device responded |

## Verification
The bench sweeps every size and window offset in both directions, and it varies the downstream delay. A wrong lane shift or wrong byte enables would show up as misplaced data or misplaced enables. Byte and word probes of the address port are replayed against a known latch value, because a decoder that let narrow accesses through would corrupt the address. Misaligned, disabled and unanswered accesses must each return masked all ones without reaching the downstream port. Latch readback is checked with every bit set, which catches a design that stores the reserved bits or loses the extended offset bits.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   localparam logic [1:0] SZ_BYTE  = 2'd0;
   localparam logic [1:0] SZ_WORD  = 2'd1;
   localparam logic [1:0] SZ_DWORD = 2'd2;

   // latch bits that hold state; the rest read as zero
   localparam logic [31:0] LATCH_KEEP = 32'h8FFF_FFFC;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CFG  = 2'd1,
      ST_RESP = 2'd2
   } cfgp_state_e;

   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_mask = 32'h0000_00FF;
         SZ_WORD: size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/cfgp_addr_latch.sv
module cfgp_addr_latch #(
   parameter bit EXT_REG_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        en_d,
   input  logic [3:0]  ext_d,
   input  logic [21:0] low_d,
   output logic [31:0] latch_q,
   output logic        enable,
   output logic [7:0]  bus,
   output logic [7:0]  devfn,
   output logic [3:0]  reg_hi,
   output logic [5:0]  dw_idx
);

   logic        en_q;
   logic [3:0]  ext_q;
   logic [21:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         low_q <= '0;
      end else if (wr_en) begin
         en_q  <= en_d;
         low_q <= low_d;
      end
   end

   generate
      if (EXT_REG_EN) begin : g_ext
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ext_q <= '0;
            else if (wr_en) ext_q <= ext_d;
         end
      end else begin : g_noext
         assign ext_q = 4'h0;
      end
   endgenerate

   assign latch_q = {en_q, 3'b000, ext_q, low_q, 2'b00};
   assign enable  = en_q;
   assign bus     = low_q[21:14];
   assign devfn   = low_q[13:6];
   assign dw_idx  = low_q[5:0];
   assign reg_hi  = ext_q;

endmodule

// File: rtl/cfgp_lane_map.sv
module cfgp_lane_map
   import cfgp_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int NB    = DATA_W / 8
) (
   input  logic [1:0]        size,
   input  logic [1:0]        offs,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] rdata_in,
   output logic [NB-1:0]     be,
   output logic              aligned,
   output logic [DATA_W-1:0] wdata_out,
   output logic [DATA_W-1:0] rdata_out
);

   generate
      if (DATA_W != 32) begin : g_bad_w
         $error("cfgp_lane_map: DATA_W must be 32");
      end
      for (genvar i = 0; i < NB; i++) begin : g_lane
         localparam logic [1:0] LI = i[1:0];
         always_comb begin
            case (size)
               SZ_BYTE:  be[i] = (offs == LI);
               SZ_WORD:  be[i] = (offs[1] == LI[1]);
               SZ_DWORD: be[i] = 1'b1;
               default:  be[i] = 1'b0;
            endcase
         end
      end
   endgenerate

   always_comb begin
      case (size)
         SZ_BYTE:  aligned = 1'b1;
         SZ_WORD:  aligned = ~offs[0];
         SZ_DWORD: aligned = (offs == 2'b00);
         default:  aligned = 1'b0;
      endcase
   end

   assign wdata_out = wdata_in << {offs, 3'b000};
   assign rdata_out = (rdata_in >> {offs, 3'b000}) & size_mask(size);

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
   import cfgp_pkg::*;
#(
   parameter int                IO_AW      = 16,
   parameter logic [IO_AW-1:0]  ADDR_PORT  = 'h0CF8,
   parameter logic [IO_AW-1:0]  DATA_PORT  = 'h0CFC,
   parameter bit                EXT_REG_EN = 1'b1,
   parameter int                DATA_W     = 32,
   parameter int                BUS_W      = 8,
   parameter int                DEVFN_W    = 8,
   parameter int                REG_W      = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IO_AW-1:0]      io_addr,
   input  logic [1:0]            io_size,
   input  logic                  io_rd,
   input  logic                  io_wr,
   input  logic [DATA_W-1:0]     io_wdata,
   output logic [DATA_W-1:0]     io_rdata,
   output logic                  io_ready,
   output logic                  cfg_valid,
   output logic                  cfg_write,
   output logic [BUS_W-1:0]      cfg_bus,
   output logic [DEVFN_W-1:0]    cfg_devfn,
   output logic [REG_W-1:0]      cfg_reg,
   output logic [DATA_W/8-1:0]   cfg_be,
   output logic [DATA_W-1:0]     cfg_wdata,
   input  logic [DATA_W-1:0]     cfg_rdata,
   input  logic                  cfg_ack,
   input  logic                  cfg_err
);

   localparam int NB    = DATA_W / 8;
   localparam int OFS_W = $clog2(NB);

   generate
      if (DATA_W != 32) begin : g_chk_dw
         $error("cfg_port_bridge: DATA_W must be 32");
      end
      if (BUS_W != 8 || DEVFN_W != 8) begin : g_chk_fields
         $error("cfg_port_bridge: bus and devfn fields are 8 bits");
      end
      if (REG_W != 12) begin : g_chk_reg
         $error("cfg_port_bridge: REG_W must be 12");
      end
      if (ADDR_PORT[OFS_W-1:0] != '0 || DATA_PORT[OFS_W-1:0] != '0) begin : g_chk_ports
         $error("cfg_port_bridge: ports must be dword aligned");
      end
   endgenerate

   cfgp_state_e state_q;

   logic [DATA_W-1:0] rdata_q;
   logic [NB-1:0]     be_q;
   logic [DATA_W-1:0] wdata_q;
   logic              write_q;
   logic [1:0]        ofs_q;
   logic [1:0]        size_q;

   // address latch
   logic [31:0] lat_q;
   logic        lat_enable;
   logic [7:0]  lat_bus;
   logic [7:0]  lat_devfn;
   logic [3:0]  lat_reg_hi;
   logic [5:0]  lat_dw_idx;
   logic        lat_wr;

   // decode
   logic strobe;
   logic lat_sel;
   logic win_sel;

   // lane mapping
   logic [1:0]        map_size;
   logic [1:0]        map_offs;
   logic [NB-1:0]     map_be;
   logic              map_aligned;
   logic [DATA_W-1:0] map_wdata;
   logic [DATA_W-1:0] map_rdata;

   assign strobe  = io_rd | io_wr;
   assign lat_sel = (io_addr == ADDR_PORT) && (io_size == SZ_DWORD);
   assign win_sel = (io_addr[IO_AW-1:OFS_W] == DATA_PORT[IO_AW-1:OFS_W]) && map_aligned;
   assign lat_wr  = (state_q == ST_IDLE) && io_wr && lat_sel;

   cfgp_addr_latch #(
      .EXT_REG_EN (EXT_REG_EN)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lat_wr),
      .en_d    (io_wdata[31]),
      .ext_d   (io_wdata[27:24]),
      .low_d   (io_wdata[23:2]),
      .latch_q (lat_q),
      .enable  (lat_enable),
      .bus     (lat_bus),
      .devfn   (lat_devfn),
      .reg_hi  (lat_reg_hi),
      .dw_idx  (lat_dw_idx)
   );

   // while idle the live bus drives the map; afterwards the captured access does
   assign map_size = (state_q == ST_IDLE) ? io_size : size_q;
   assign map_offs = (state_q == ST_IDLE) ? io_addr[1:0] : ofs_q;

   cfgp_lane_map #(
      .DATA_W (DATA_W)
   ) u_lanes (
      .size      (map_size),
      .offs      (map_offs),
      .wdata_in  (io_wdata),
      .rdata_in  (cfg_rdata),
      .be        (map_be),
      .aligned   (map_aligned),
      .wdata_out (map_wdata),
      .rdata_out (map_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rdata_q <= '0;
         be_q    <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
         ofs_q   <= '0;
         size_q  <= SZ_BYTE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (strobe) begin
                  if (lat_sel) begin
                     rdata_q <= io_wr ? '0 : lat_q;
                     state_q <= ST_RESP;
                  end else if (win_sel && lat_enable) begin
                     be_q    <= map_be;
                     wdata_q <= map_wdata;
                     write_q <= io_wr;
                     ofs_q   <= io_addr[1:0];
                     size_q  <= io_size;
                     state_q <= ST_CFG;
                  end else begin
                     rdata_q <= io_wr ? '0 : size_mask(io_size);
                     state_q <= ST_RESP;
                  end
               end
            end
            ST_CFG: begin
               if (cfg_ack) begin
                  if (write_q)      rdata_q <= '0;
                  else if (cfg_err) rdata_q <= size_mask(size_q);
                  else              rdata_q <= map_rdata;
                  state_q <= ST_RESP;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign io_ready  = (state_q == ST_RESP);
   assign io_rdata  = rdata_q;
   assign cfg_valid = (state_q == ST_CFG);
   assign cfg_write = write_q;
   assign cfg_be    = be_q;
   assign cfg_wdata = wdata_q;
   assign cfg_bus   = lat_bus;
   assign cfg_devfn = lat_devfn;
   assign cfg_reg   = {lat_reg_hi, lat_dw_idx, 2'b00};

endmodule

// File: rtl/cfgp_bridge_chk.sv
module cfgp_bridge_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        io_ready,
   input logic        cfg_valid,
   input logic        cfg_ack,
   input logic [3:0]  cfg_be,
   input logic [31:0] cfg_wdata,
   input logic [11:0] cfg_reg,
   input logic [7:0]  cfg_bus,
   input logic [7:0]  cfg_devfn,
   input logic        cfg_write,
   input logic        lat_en,
   input logic        lat_wr,
   input logic [31:0] lat_wdata,
   input logic [31:0] lat_q
);

   // R10: request held until acknowledged
   assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_ack) |=> cfg_valid);

   // R10: request fields stable while waiting
   assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_ack) |=> ($stable(cfg_be) && $stable(cfg_wdata) && $stable(cfg_reg)
                                   && $stable(cfg_bus) && $stable(cfg_devfn) && $stable(cfg_write)));

   // R10: completion is a single pulse
   assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      io_ready |=> !io_ready);

   // R8: nothing forwarded while the enable bit is clear
   assert_no_req_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> lat_en);

   // R5: only legal byte-enable patterns reach downstream
   assert_be_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (cfg_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF}));

   // R2: a latch write is visible in the next cycle with reserved bits cleared
   assert_latch_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lat_wr |=> (lat_q == ($past(lat_wdata) & 32'h8FFF_FFFC)));

   // R10: no request and completion at the same time
   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_valid && io_ready));

endmodule

bind cfg_port_bridge cfgp_bridge_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_ready  (io_ready),
   .cfg_valid (cfg_valid),
   .cfg_ack   (cfg_ack),
   .cfg_be    (cfg_be),
   .cfg_wdata (cfg_wdata),
   .cfg_reg   (cfg_reg),
   .cfg_bus   (cfg_bus),
   .cfg_devfn (cfg_devfn),
   .cfg_write (cfg_write),
   .lat_en    (lat_enable),
   .lat_wr    (lat_wr),
   .lat_wdata (io_wdata),
   .lat_q     (lat_q)
);

// File: tb/cfg_port_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb_top;

   localparam logic [15:0] AP = 16'h0CF8;
   localparam logic [15:0] DP = 16'h0CFC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [1:0]  io_size = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [31:0] io_wdata = '0;
   logic [31:0] io_rdata;
   logic        io_ready;
   logic        cfg_valid;
   logic        cfg_write;
   logic [7:0]  cfg_bus;
   logic [7:0]  cfg_devfn;
   logic [11:0] cfg_reg;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata = '0;
   logic        cfg_ack = 1'b0;
   logic        cfg_err = 1'b0;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // downstream model settings and captures
   int          dn_delay = 0;
   logic [31:0] dn_data = '0;
   logic        dn_err = 1'b0;
   int          req_count = 0;
   logic [3:0]  cap_be;
   logic [31:0] cap_wdata;
   logic        cap_write;
   logic [7:0]  cap_bus;
   logic [7:0]  cap_devfn;
   logic [11:0] cap_reg;

   always #2.5 clk = ~clk;

   cfg_port_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
      .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .io_ready(io_ready), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
      .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cfg_ack(cfg_ack), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mask_of(input int sz);
      if (sz == 0) return 32'h0000_00FF;
      if (sz == 1) return 32'h0000_FFFF;
      return 32'hFFFF_FFFF;
   endfunction

   function automatic logic [3:0] be_of(input int sz, input int o);
      if (sz == 0) return 4'(1 << o);
      if (sz == 1) return 4'(3 << o);
      return 4'hF;
   endfunction

   function automatic logic [31:0] lanes_of(input logic [3:0] be);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
      return m;
   endfunction

   // downstream responder
   initial begin
      int dcnt;
      dcnt = 0;
      forever begin
         @(negedge clk);
         if (cfg_ack) begin
            cfg_ack = 1'b0;
            cfg_err = 1'b0;
            dcnt = 0;
         end else if (cfg_valid) begin
            if (dcnt >= dn_delay) begin
               cfg_ack   = 1'b1;
               cfg_rdata = dn_data;
               cfg_err   = dn_err;
               cap_be    = cfg_be;
               cap_wdata = cfg_wdata;
               cap_write = cfg_write;
               cap_bus   = cfg_bus;
               cap_devfn = cfg_devfn;
               cap_reg   = cfg_reg;
               req_count++;
            end else begin
               dcnt++;
            end
         end
      end
   end

   task automatic io_access(input logic [15:0] a, input int sz, input bit wr,
                            input logic [31:0] wd, output logic [31:0] rd, output int lat);
      @(negedge clk);
      io_addr  = a;
      io_size  = 2'(sz);
      io_wdata = wd;
      io_wr    = wr;
      io_rd    = !wr;
      lat = 0;
      rd  = '0;
      while (1) begin
         @(negedge clk);
         lat++;
         if (io_ready) begin
            rd = io_rdata;
            break;
         end
         if (lat > 60) begin
            check(1'b0, "watchdog access hung", 32'(lat), 32'd60);
            break;
         end
      end
      io_rd = 1'b0;
      io_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(1'b0, "global watchdog", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int lat;
      int rc0;
      logic [31:0] latv;

      repeat (3) @(negedge clk);
      // R1: reset state
      check(io_ready === 1'b0, "R1 io_ready low in reset", 32'(io_ready), 32'd0);
      check(cfg_valid === 1'b0, "R1 cfg_valid low in reset", 32'(cfg_valid), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(io_ready === 1'b0 && cfg_valid === 1'b0, "R1 idle after reset", {io_ready, cfg_valid}, 32'd0);
      io_access(AP, 2, 1'b0, '0, rd, lat);
      check(rd === 32'h0, "R1 latch reset value", rd, 32'h0);

      // R2: latch readback and latency
      io_access(AP, 2, 1'b1, 32'h8000_0000, rd, lat);
      check(lat == 1, "R2 latch write latency", 32'(lat), 32'd1);
      io_access(AP, 2, 1'b0, '0, rd, lat);
      check(rd === 32'h8000_0000, "R2 enable-only readback", rd, 32'h8000_0000);
      check(lat == 1, "R2 latch read latency", 32'(lat), 32'd1);
      io_access(AP, 2, 1'b1, 32'hFFFF_FFFF, rd, lat);
      io_access(AP, 2, 1'b0, '0, rd, lat);
      check(rd === 32'h8FFF_FFFC, "R2 reserved bits read zero", rd, 32'h8FFF_FFFC);

      // R3: narrow accesses to the address port range
      latv = 32'h8A5C_3BF4;
      io_access(AP, 2, 1'b1, latv, rd, lat);
      rc0 = req_count;
      io_access(AP + 16'd3, 0, 1'b1, 32'h0000_0001, rd, lat);
      io_access(AP, 1, 1'b1, 32'h0000_1234, rd, lat);
      io_access(AP + 16'd2, 1, 1'b1, 32'h0000_0000, rd, lat);
      io_access(AP, 2, 1'b0, '0, rd, lat);
      check(rd === latv, "R3 narrow writes leave latch", rd, latv);
      for (int o = 0; o < 4; o++) begin
         io_access(AP + 16'(o), 0, 1'b0, '0, rd, lat);
         check(rd === 32'hFF, "R3 byte read of address port", rd, 32'hFF);
      end
      io_access(AP, 1, 1'b0, '0, rd, lat);
      check(rd === 32'hFFFF, "R3 word read of address port", rd, 32'hFFFF);
      check(req_count == rc0, "R3 no request from address port", 32'(req_count - rc0), 32'd0);

      // R4..R7, R10: sweep of sizes, offsets and directions
      for (int sz = 0; sz < 3; sz++) begin
         for (int o = 0; o < 4; o++) begin
            for (int w = 0; w < 2; w++) begin
               logic [31:0] pat;
               logic [31:0] exp_r;
               logic [31:0] lm;
               logic [3:0]  eb;
               bit          ok_al;
               ok_al = (sz == 0) || (sz == 1 && (o % 2) == 0) || (sz == 2 && o == 0);
               pat = 32'hA1B2_C3D4 ^ 32'(sz * 32'h0101_0101 + o * 32'h1111_0000 + w);
               latv = {1'b1, 3'b000, 4'(sz * 4 + o + 3), 8'(8'h20 + o), 8'(8'h40 + sz * 8 + w), 6'(sz * 12 + o * 3 + w), 2'b00};
               io_access(AP, 2, 1'b1, latv, rd, lat);
               dn_delay = (sz + o + w) % 4;
               dn_data  = pat;
               dn_err   = 1'b0;
               rc0 = req_count;
               io_access(DP + 16'(o), sz, w[0], pat, rd, lat);
               if (!ok_al) begin
                  check(req_count == rc0, "R5 misaligned not forwarded", 32'(req_count - rc0), 32'd0);
                  if (w == 0)
                     check(rd === mask_of(sz), "R5 misaligned read all ones", rd, mask_of(sz));
               end else begin
                  eb = be_of(sz, o);
                  lm = lanes_of(eb);
                  check(req_count == rc0 + 1, "R10 one request issued", 32'(req_count - rc0), 32'd1);
                  check(lat == 2 + dn_delay, "R10 latency 2+d", 32'(lat), 32'(2 + dn_delay));
                  check(cap_be === eb, "R5 byte enables", 32'(cap_be), 32'(eb));
                  check(cap_bus === latv[23:16] && cap_devfn === latv[15:8],
                        "R4 bus and devfn", {16'h0, cap_bus, cap_devfn}, {16'h0, latv[23:16], latv[15:8]});
                  check(cap_reg === {latv[27:24], latv[7:2], 2'b00}, "R4 register offset",
                        32'(cap_reg), 32'({latv[27:24], latv[7:2], 2'b00}));
                  check(cap_write === w[0], "R6 write flag", 32'(cap_write), 32'(w));
                  if (w == 1) begin
                     check((cap_wdata & lm) === ((pat << (8 * o)) & lm), "R6 write lanes",
                           cap_wdata & lm, (pat << (8 * o)) & lm);
                  end else begin
                     exp_r = (pat >> (8 * o)) & mask_of(sz);
                     check(rd === exp_r, "R7 read lane extract", rd, exp_r);
                  end
               end
            end
         end
      end

      // R9: no device responds
      latv = 32'h8000_0100;
      io_access(AP, 2, 1'b1, latv, rd, lat);
      for (int sz = 0; sz < 3; sz++) begin
         dn_delay = sz;
         dn_err   = 1'b1;
         dn_data  = 32'h1234_5678;
         io_access(DP, sz, 1'b0, '0, rd, lat);
         check(rd === mask_of(sz), "R9 unanswered read all ones", rd, mask_of(sz));
      end
      dn_err = 1'b0;

      // R8: enable bit clear
      latv = 32'h0A5C_3BF4;
      io_access(AP, 2, 1'b1, latv, rd, lat);
      rc0 = req_count;
      for (int sz = 0; sz < 3; sz++) begin
         io_access(DP, sz, 1'b0, '0, rd, lat);
         check(rd === mask_of(sz), "R8 disabled read all ones", rd, mask_of(sz));
         check(lat == 1, "R8 disabled fast completion", 32'(lat), 32'd1);
         io_access(DP, sz, 1'b1, 32'hDEAD_BEEF, rd, lat);
      end
      check(req_count == rc0, "R8 disabled issues no request", 32'(req_count - rc0), 32'd0);
      io_access(AP, 2, 1'b0, '0, rd, lat);
      check(rd === latv, "R8 latch intact after dropped writes", rd, latv);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule